// File: doc/BRIEF.md
# Configurable Product-Term Macrocell Register

This block is one logic cell of a product-term programmable logic array, built as ordinary synthesizable logic and set up by a static configuration word. Five product terms arrive from the array. A per-term routing code sends each term either into an OR sum with a programmable output inversion, or onto a control of the cell's flip-flop: asynchronous clear, asynchronous preset, array clock, clock enable, or a second data input.

The flip-flop acts as a D, T, JK or SR element. It is clocked by one of two global clocks, by a global clock qualified by an enable, or by a clock formed from product terms. Its data input can take the pin input directly instead of the logic sum. A bypass bit sends the combinational sum to the output in place of the register. The output is driven on two ports: one for the cell's pin and one copy that feeds back into the array.

The configuration word is held constant while the cell runs. Between configurations, the cell is first cleared through the global clear.

Top module: `mcell_top`

## Requirements
- R1: Product term k (k = 0..4) is routed by the 3-bit code `cfg_i[3k+2:3k]`. The codes are: 0 sum, 1 clear, 2 preset, 3 array clock, 4 clock enable, 5 second data input. Codes 6 and 7 leave the term unused. A term has no effect on any destination other than the one its code names.
- R2: The logic result is the OR of the sum-routed terms XOR `cfg_i[15]`. When `cfg_i[18]` is 1, `mc_o` shows this result combinationally.
- R3: `cfg_i[17:16]` picks the register kind. With 0 (D) the register loads the data input on a clock edge. With 1 (T) it inverts when the data input is 1 and holds otherwise.
- R4: With kind 2 (JK), J is the data input and K is the OR of code-5 terms. The pairs act as follows: J=1,K=0 sets; J=0,K=1 clears; J=K=1 inverts; J=K=0 holds.
- R5: With kind 3 (SR), S is the data input and R is the OR of code-5 terms. S alone sets, R alone clears, and S=R=1 or S=R=0 holds.
- R6: `cfg_i[20:19]` selects the clocking. With 0, the rising edge of the global clock chosen by `cfg_i[21]` is used (0: `gclk0_i`, 1: `gclk1_i`). With 1, that same clock is used, qualified by an enable. With 2, the rising edge of the OR of code-3 terms is used.
- R7: The clear comes from `rst_ni` low when `cfg_i[22]` is 0, or from the OR of code-1 terms when it is 1. The preset is the OR of code-2 terms. Both act asynchronously, and clear wins when both are active.
- R8: When `cfg_i[23]` is 1, the register's data input is `pin_i` instead of the logic result.
- R9: `fb_o` always equals `mc_o`.
- R10: In mode 1, the enable is the OR of code-4 terms when `cfg_i[24]` is 0, and `gen_i` when it is 1. A clock edge with the enable low leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gclk0_i | input | 1 | Global clock 0 |
| gclk1_i | input | 1 | Global clock 1 |
| rst_ni | input | 1 | Global active-low clear |
| gen_i | input | 1 | Global clock enable |
| pt_i | input | 5 | Product terms from the array |
| pin_i | input | 1 | Direct pin input for fast capture |
| cfg_i | input | 25 | Static configuration word |
| mc_o | output | 1 | Cell output |
| fb_o | output | 1 | Feedback copy of the cell output |

## Verification
The hardest case to reach is the array-clock mode. In that mode, a product term acts as the register's clock while its sibling terms carry the data. A careless change of all five terms at once races the clock against its own data. The stimulus therefore moves each array-clock step in two phases. First the data, clear and preset terms change while the clock term is held low. Then the clock term rises. This gives one clean edge per step. A second delicate point is a preset held across the release of a clear: the register stays cleared until the next clock edge. The directed tests cover this case, and random stimulus that leans toward rare clear and preset pulses covers it again for every kind and clock mode.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned PT_NUM = 5;
  localparam int unsigned RT_W   = 3;

  typedef enum logic [2:0] {
    RT_SUM  = 3'd0,
    RT_CLR  = 3'd1,
    RT_PRE  = 3'd2,
    RT_ACLK = 3'd3,
    RT_CEN  = 3'd4,
    RT_AUX  = 3'd5
  } route_e;

  typedef enum logic [1:0] {FF_D = 2'd0, FF_T = 2'd1, FF_JK = 2'd2, FF_SR = 2'd3} ff_kind_e;

  typedef enum logic [1:0] {CK_GLOBAL = 2'd0, CK_GATED = 2'd1, CK_ARRAY = 2'd2, CK_RSVD = 2'd3} clk_mode_e;

  typedef struct packed {
    logic                         cen_glb;   // [24]
    logic                         fast_in;   // [23]
    logic                         clr_pterm; // [22]
    logic                         gclk_sel;  // [21]
    clk_mode_e                    clk_mode;  // [20:19]
    logic                         bypass;    // [18]
    ff_kind_e                     kind;      // [17:16]
    logic                         invert;    // [15]
    logic [PT_NUM-1:0][RT_W-1:0]  route;     // [14:0]
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/mcell_ptsel.sv
module mcell_ptsel
  import mcell_pkg::*;
(
  input  logic [PT_NUM-1:0]           pt_i,
  input  logic [PT_NUM-1:0][RT_W-1:0] route_i,
  input  logic                        invert_i,
  output logic                        sum_o,
  output logic                        aux_o,
  output logic                        clr_o,
  output logic                        pre_o,
  output logic                        aclk_o,
  output logic                        cen_o
);
  logic [PT_NUM-1:0] to_sum, to_aux, to_clr, to_pre, to_aclk, to_cen;

  for (genvar k = 0; k < PT_NUM; k++) begin : g_pt
    assign to_sum[k]  = pt_i[k] && (route_i[k] == RT_SUM);
    assign to_aux[k]  = pt_i[k] && (route_i[k] == RT_AUX);
    assign to_clr[k]  = pt_i[k] && (route_i[k] == RT_CLR);
    assign to_pre[k]  = pt_i[k] && (route_i[k] == RT_PRE);
    assign to_aclk[k] = pt_i[k] && (route_i[k] == RT_ACLK);
    assign to_cen[k]  = pt_i[k] && (route_i[k] == RT_CEN);
  end

  // polarity stage after the OR
  assign sum_o  = (|to_sum) ^ invert_i;
  assign aux_o  = |to_aux;
  assign clr_o  = |to_clr;
  assign pre_o  = |to_pre;
  assign aclk_o = |to_aclk;
  assign cen_o  = |to_cen;
endmodule

// File: rtl/mcell_nxt.sv
module mcell_nxt
  import mcell_pkg::*;
(
  input  ff_kind_e kind_i,
  input  logic     q_i,
  input  logic     a_i,  // D, T, J or S
  input  logic     b_i,  // K or R
  output logic     q_o
);
  always_comb begin
    case (kind_i)
      FF_D:    q_o = a_i;
      FF_T:    q_o = q_i ^ a_i;
      FF_JK:   q_o = (a_i & ~q_i) | (~b_i & q_i);
      default: q_o = (a_i & ~b_i) | (q_i & ~(b_i & ~a_i)); // S=R=1 holds
    endcase
  end
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_pkg::*;
(
  input  logic      gclk0_i,
  input  logic      gclk1_i,
  input  logic      rst_ni,
  input  logic      gen_i,
  input  logic      pin_i,
  input  logic      data_i,
  input  logic      aux_i,
  input  logic      clr_pt_i,
  input  logic      pre_i,
  input  logic      aclk_i,
  input  logic      cen_pt_i,
  input  ff_kind_e  kind_i,
  input  clk_mode_e clk_mode_i,
  input  logic      gclk_sel_i,
  input  logic      cen_glb_i,
  input  logic      clr_pterm_i,
  input  logic      fast_in_i,
  output logic      q_o
);
  logic clr, reg_clk, ena, d_in, q_q, q_nxt;

  assign clr = clr_pterm_i ? clr_pt_i : ~rst_ni;

  always_comb begin
    case (clk_mode_i)
      CK_ARRAY: reg_clk = aclk_i;
      default:  reg_clk = gclk_sel_i ? gclk1_i : gclk0_i;
    endcase
  end

  assign ena  = (clk_mode_i == CK_GATED) ? (cen_glb_i ? gen_i : cen_pt_i) : 1'b1;
  assign d_in = fast_in_i ? pin_i : data_i;

  mcell_nxt u_nxt (
    .kind_i (kind_i),
    .q_i    (q_q),
    .a_i    (d_in),
    .b_i    (aux_i),
    .q_o    (q_nxt)
  );

  // clear outranks preset, both outrank the clock
  always_ff @(posedge reg_clk or posedge clr or posedge pre_i) begin
    if (clr)        q_q <= 1'b0;
    else if (pre_i) q_q <= 1'b1;
    else if (ena)   q_q <= q_nxt;
  end

  assign q_o = q_q;

  // R7
  clr_wins_chk: assert property (@(posedge gclk0_i) disable iff (!rst_ni)
    clr |-> !q_q);

  // R3
  d_capture_chk: assert property (@(posedge gclk0_i) disable iff (!rst_ni)
    (clk_mode_i == CK_GLOBAL && !gclk_sel_i && kind_i == FF_D && !fast_in_i && !clr && !pre_i)
    |=> (clr || pre_i || q_q == $past(data_i)));

  // R8
  fast_capture_chk: assert property (@(posedge gclk0_i) disable iff (!rst_ni)
    (clk_mode_i == CK_GLOBAL && !gclk_sel_i && kind_i == FF_D && fast_in_i && !clr && !pre_i)
    |=> (clr || pre_i || q_q == $past(pin_i)));

  // R10
  gated_hold_chk: assert property (@(posedge gclk0_i) disable iff (!rst_ni)
    (clk_mode_i == CK_GATED && !gclk_sel_i && !ena && !clr && !pre_i)
    |=> (clr || pre_i || q_q == $past(q_q)));

  // R4
  jk_toggle_chk: assert property (@(posedge gclk0_i) disable iff (!rst_ni)
    (clk_mode_i == CK_GLOBAL && !gclk_sel_i && kind_i == FF_JK && d_in && aux_i && !clr && !pre_i)
    |=> (clr || pre_i || q_q == !$past(q_q)));
endmodule

// File: rtl/mcell_top.sv
module mcell_top
  import mcell_pkg::*;
(
  input  logic              gclk0_i,
  input  logic              gclk1_i,
  input  logic              rst_ni,
  input  logic              gen_i,
  input  logic [PT_NUM-1:0] pt_i,
  input  logic              pin_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              mc_o,
  output logic              fb_o
);
  cfg_t cfg;
  logic sum_x, aux, clr_pt, pre, aclk, cen_pt, q;

  assign cfg = cfg_t'(cfg_i);

  mcell_ptsel u_ptsel (
    .pt_i     (pt_i),
    .route_i  (cfg.route),
    .invert_i (cfg.invert),
    .sum_o    (sum_x),
    .aux_o    (aux),
    .clr_o    (clr_pt),
    .pre_o    (pre),
    .aclk_o   (aclk),
    .cen_o    (cen_pt)
  );

  mcell_reg u_reg (
    .gclk0_i     (gclk0_i),
    .gclk1_i     (gclk1_i),
    .rst_ni      (rst_ni),
    .gen_i       (gen_i),
    .pin_i       (pin_i),
    .data_i      (sum_x),
    .aux_i       (aux),
    .clr_pt_i    (clr_pt),
    .pre_i       (pre),
    .aclk_i      (aclk),
    .cen_pt_i    (cen_pt),
    .kind_i      (cfg.kind),
    .clk_mode_i  (cfg.clk_mode),
    .gclk_sel_i  (cfg.gclk_sel),
    .cen_glb_i   (cfg.cen_glb),
    .clr_pterm_i (cfg.clr_pterm),
    .fast_in_i   (cfg.fast_in),
    .q_o         (q)
  );

  assign mc_o = cfg.bypass ? sum_x : q;
  assign fb_o = mc_o;
endmodule

// File: tb/mcell_top_tb_top.sv
module mcell_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 25;

  logic         gclk0 = 1'b0;
  logic         gclk1 = 1'b0;
  logic         rst_n = 1'b0;
  logic         gen   = 1'b0;
  logic         pin   = 1'b0;
  logic [4:0]   pt    = '0;
  logic [W-1:0] cfg   = '0;
  logic         mc, fb;
  logic         m_q, m_clr, m_pre;
  int           n_chk = 0;
  int           n_fail = 0;

  mcell_top dut_i (
    .gclk0_i (gclk0),
    .gclk1_i (gclk1),
    .rst_ni  (rst_n),
    .gen_i   (gen),
    .pt_i    (pt),
    .pin_i   (pin),
    .cfg_i   (cfg),
    .mc_o    (mc),
    .fb_o    (fb)
  );

  always #(CLK_PERIOD/2) gclk0 = ~gclk0;
  always @(posedge gclk0) gclk1 <= ~gclk1;

  // layout per R1..R10: {cen,fast,csrc,gsel,mode,byp,kind,inv,r4,r3,r2,r1,r0}
  function automatic logic [W-1:0] mk(input logic [2:0] r4, r3, r2, r1, r0,
                                      input logic inv, input logic [1:0] kind, input logic byp,
                                      input logic [1:0] mode, input logic gsel, csrc, fast, cen);
    return {cen, fast, csrc, gsel, mode, byp, kind, inv, r4, r3, r2, r1, r0};
  endfunction

  function automatic logic route_or(input logic [W-1:0] c, input logic [4:0] p, input logic [2:0] code);
    logic r = 1'b0;
    for (int k = 0; k < 5; k++) if (p[k] && c[3*k +: 3] == code) r = 1'b1;
    return r;
  endfunction

  typedef struct packed {
    logic [W-1:0] cfg;
    logic [4:0]   pt;
    logic         exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{mk(0,0,0,0,0, 0,0,1,0,0,0,0,0), 5'b00000, 1'b0},
    '{mk(0,0,0,0,0, 0,0,1,0,0,0,0,0), 5'b00100, 1'b1},
    '{mk(0,0,0,0,0, 1,0,1,0,0,0,0,0), 5'b00000, 1'b1},
    '{mk(0,0,0,0,0, 1,0,1,0,0,0,0,0), 5'b10000, 1'b0},
    '{mk(6,6,6,6,0, 0,0,1,0,0,0,0,0), 5'b11110, 1'b0},
    '{mk(6,6,6,6,0, 0,0,1,0,0,0,0,0), 5'b00001, 1'b1},
    '{mk(0,0,0,5,0, 0,0,1,0,0,0,0,0), 5'b00010, 1'b0},
    '{mk(0,0,0,5,0, 0,0,1,0,0,0,0,0), 5'b00011, 1'b1},
    '{mk(3,4,0,0,0, 0,0,1,0,0,0,0,0), 5'b11000, 1'b0},
    '{mk(3,4,0,0,0, 1,0,1,0,0,0,0,0), 5'b11000, 1'b1},
    '{mk(0,0,2,0,0, 0,0,1,0,0,0,0,0), 5'b00100, 1'b0},
    '{mk(7,0,1,0,0, 1,0,1,0,0,0,0,0), 5'b10100, 1'b1}
  };

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // clear with the global source, then switch to c while all clocks are low
  task automatic setup(input logic [W-1:0] c);
    pt = '0; pin = 1'b0; gen = 1'b0; rst_n = 1'b0;
    cfg = c & ~(W'(1) << 22);
    @(negedge gclk0);
    while (gclk1) @(negedge gclk0);
    cfg = c; rst_n = 1'b1;
    m_q = 1'b0; m_clr = 1'b0; m_pre = 1'b0;
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(input logic [4:0] p, input logic pn, input logic gn, input logic rn, input string tag);
    logic [1:0] md;
    logic [4:0] amask;
    logic clr_n, pre_n, edge_s, ena, j, k, exp_out;
    md = cfg[20:19];
    for (int i = 0; i < 5; i++) amask[i] = (cfg[3*i +: 3] == 3'd3);
    clr_n  = cfg[22] ? route_or(cfg, p, 3'd1) : !rn;
    pre_n  = route_or(cfg, p, 3'd2);
    edge_s = (md == 2'd2) ? route_or(cfg, p, 3'd3) : (cfg[21] ? !gclk1 : 1'b1);
    pin = pn; gen = gn; rst_n = rn;
    if (md == 2'd2) begin
      pt = p & ~amask;
      #1;
    end
    pt = p;
    if ((clr_n && !m_clr) || (pre_n && !m_pre)) m_q = clr_n ? 1'b0 : 1'b1;
    m_clr = clr_n; m_pre = pre_n;
    ena = (md == 2'd1) ? (cfg[24] ? gn : route_or(cfg, p, 3'd4)) : 1'b1;
    j = cfg[23] ? pn : (route_or(cfg, p, 3'd0) ^ cfg[15]);
    k = route_or(cfg, p, 3'd5);
    if (edge_s) begin
      if (m_clr) m_q = 1'b0;
      else if (m_pre) m_q = 1'b1;
      else if (ena) begin
        case (cfg[17:16])
          2'd0: m_q = j;
          2'd1: m_q = m_q ^ j;
          2'd2: m_q = (j && k) ? !m_q : j ? 1'b1 : k ? 1'b0 : m_q;
          default: m_q = (j && k) ? m_q : j ? 1'b1 : k ? 1'b0 : m_q;
        endcase
      end
    end
    @(negedge gclk0);
    exp_out = cfg[18] ? (route_or(cfg, p, 3'd0) ^ cfg[15]) : m_q;
    chk(tag, mc, exp_out);
    chk({tag, " feedback R9"}, fb, exp_out);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] c;
    // reset state, R7
    cfg = mk(0,0,0,0,0, 0,0,0,0,0,0,0,0);
    rst_n = 1'b0;
    repeat (3) @(negedge gclk0);
    chk("R7 reset mc", mc, 1'b0);
    chk("R7 reset fb R9", fb, 1'b0);

    // R1/R2 combinational vectors, register held clear
    for (int v = 0; v < 12; v++) begin
      cfg = VECS[v].cfg; pt = VECS[v].pt; pin = 1'b0;
      #2;
      chk($sformatf("R1/R2 vector %0d", v), mc, VECS[v].exp);
      chk($sformatf("R1/R2 vector %0d fb R9", v), fb, VECS[v].exp);
      @(negedge gclk0);
    end

    // R3 D and T
    setup(mk(0,0,0,0,0, 0,0,0,0,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R3 D"); chk("R3 D load 1", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R3 D"); chk("R3 D load 0", mc, 1'b0);
    setup(mk(0,0,0,0,0, 0,1,0,0,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R3 T"); chk("R3 T toggle up", mc, 1'b1);
    step(5'b00001, 0, 0, 1, "R3 T"); chk("R3 T toggle down", mc, 1'b0);
    step(5'b00000, 0, 0, 1, "R3 T"); chk("R3 T hold", mc, 1'b0);

    // R4 JK: pt0 J, pt1 K
    setup(mk(0,0,0,5,0, 0,2,0,0,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R4 JK"); chk("R4 JK set", mc, 1'b1);
    step(5'b00011, 0, 0, 1, "R4 JK"); chk("R4 JK toggle", mc, 1'b0);
    step(5'b00011, 0, 0, 1, "R4 JK"); chk("R4 JK toggle again", mc, 1'b1);
    step(5'b00010, 0, 0, 1, "R4 JK"); chk("R4 JK clear", mc, 1'b0);
    step(5'b00000, 0, 0, 1, "R4 JK"); chk("R4 JK hold", mc, 1'b0);

    // R5 SR: pt0 S, pt1 R
    setup(mk(0,0,0,5,0, 0,3,0,0,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R5 SR"); chk("R5 SR set", mc, 1'b1);
    step(5'b00011, 0, 0, 1, "R5 SR"); chk("R5 SR both hold 1", mc, 1'b1);
    step(5'b00010, 0, 0, 1, "R5 SR"); chk("R5 SR reset", mc, 1'b0);
    step(5'b00011, 0, 0, 1, "R5 SR"); chk("R5 SR both hold 0", mc, 1'b0);

    // R6 second global clock: rises on every other gclk0 edge
    setup(mk(0,0,0,0,0, 0,0,0,0,1,0,0,0));
    step(5'b00001, 0, 0, 1, "R6 gclk1"); chk("R6 gclk1 rise loads", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R6 gclk1"); chk("R6 gclk1 fall holds", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R6 gclk1"); chk("R6 gclk1 next rise", mc, 1'b0);

    // R6 array clock from pt4
    setup(mk(3,0,0,0,0, 0,0,0,2,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R6 array"); chk("R6 array no edge", mc, 1'b0);
    step(5'b00001, 0, 0, 1, "R6 array"); chk("R6 array still no edge", mc, 1'b0);
    step(5'b10001, 0, 0, 1, "R6 array"); chk("R6 array edge loads", mc, 1'b1);
    step(5'b10000, 0, 0, 1, "R6 array"); chk("R6 array edge loads 0", mc, 1'b0);

    // R10 enable from pt3, then from gen_i
    setup(mk(0,4,0,0,0, 0,0,0,1,0,0,0,0));
    step(5'b00001, 0, 0, 1, "R10 pt enable"); chk("R10 enable low holds", mc, 1'b0);
    step(5'b01001, 0, 0, 1, "R10 pt enable"); chk("R10 enable high loads", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R10 pt enable"); chk("R10 enable low holds 1", mc, 1'b1);
    step(5'b01000, 0, 0, 1, "R10 pt enable"); chk("R10 enable high loads 0", mc, 1'b0);
    setup(mk(0,0,0,0,0, 0,0,0,1,0,0,0,1));
    step(5'b00001, 0, 0, 1, "R10 gen"); chk("R10 gen low holds", mc, 1'b0);
    step(5'b00001, 0, 1, 1, "R10 gen"); chk("R10 gen high loads", mc, 1'b1);

    // R7 product-term clear (pt1) and preset (pt2)
    setup(mk(0,0,2,1,0, 0,0,0,0,0,1,0,0));
    step(5'b00001, 0, 0, 1, "R7 clr/pre"); chk("R7 load 1", mc, 1'b1);
    step(5'b00011, 0, 0, 1, "R7 clr/pre"); chk("R7 clear beats data", mc, 1'b0);
    step(5'b00110, 0, 0, 1, "R7 clr/pre"); chk("R7 clear beats preset", mc, 1'b0);
    step(5'b00100, 0, 0, 1, "R7 clr/pre"); chk("R7 preset after clear release", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R7 clr/pre"); chk("R7 preset released", mc, 1'b0);
    step(5'b00001, 0, 0, 0, "R7 clr/pre"); chk("R7 global clear ignored", mc, 1'b1);
    step(5'b00000, 0, 0, 1, "R7 clr/pre");
    pt = 5'b00100; #2;
    chk("R7 preset asynchronous", mc, 1'b1);
    pt = 5'b00110; #1;
    chk("R7 clear asynchronous", mc, 1'b0);
    pt = 5'b00000; m_q = 1'b0; m_clr = 1'b0; m_pre = 1'b0;
    @(negedge gclk0);

    // R8 fast input
    setup(mk(0,0,0,0,0, 0,0,0,0,0,0,1,0));
    step(5'b00000, 1, 0, 1, "R8 fast"); chk("R8 pin captured", mc, 1'b1);
    step(5'b11111, 0, 0, 1, "R8 fast"); chk("R8 sum ignored", mc, 1'b0);

    // random configurations against the reference model
    for (int kd = 0; kd < 4; kd++) begin
      for (int md = 0; md < 3; md++) begin
        for (int rep = 0; rep < 4; rep++) begin
          string tag;
          c = mk(3'($urandom_range(0,7)), 3'($urandom_range(0,7)), 3'($urandom_range(0,7)),
                 3'($urandom_range(0,7)), 3'($urandom_range(0,7)),
                 1'($urandom_range(0,1)), 2'(kd), 1'b0, 2'(md), 1'($urandom_range(0,1)),
                 1'($urandom_range(0,1)), 1'($urandom_range(0,1)), 1'($urandom_range(0,1)));
          tag = (kd == 2) ? "R4 random" : (kd == 3) ? "R5 random" : "R3 random";
          setup(c);
          for (int s = 0; s < 40; s++) begin
            logic [4:0] p;
            for (int b = 0; b < 5; b++) begin
              if (c[3*b +: 3] == 3'd1 || c[3*b +: 3] == 3'd2) p[b] = ($urandom_range(0,7) == 0);
              else p[b] = 1'($urandom_range(0,1));
            end
            step(p, 1'($urandom_range(0,1)), 1'($urandom_range(0,1)),
                 ($urandom_range(0,15) != 0), $sformatf("%s mode %0d R6", tag, md));
          end
        end
      end
    end

    report();
    $finish;
  end
endmodule